// File: doc/BRIEF.md
# Selective and Variable Row Refresh Scheduler

This block decides when each row of a dynamic memory array is refreshed and shares the array between those refresh operations and host read/write accesses. A free-running base tick marks refresh epochs. With both mode enables low it behaves as a conventional controller: every row becomes due once per base tick, whatever it holds. Two independent enables reduce the refresh work. The selective enable drops rows that hold no live data. The variable enable gives each row its own interval, a power-of-two multiple of the base tick.

Every row keeps a live flag, a 2-bit interval code and a small countdown. A granted host write marks its row live. The configuration port can mark a row dead or program its interval code. Due rows are issued one at a time, lowest index first, on the refresh command output. A refresh holds the array for a fixed number of cycles, and host requests wait during that time. A running total of issued refreshes is exported, so the work done can be compared with the count a fixed-interval controller would need.

Top module: `rfsh_scheduler`

## Requirements
- R1: After reset no refresh is issued, the refresh total is 0, every row is dead with interval code 0, and the base tick counter restarts so the first base tick falls in cycle TICK_CYCLES-1.
- R2: With both enables low, every row becomes due at every base tick and receives exactly one refresh per base tick.
- R3: With the selective enable high, a dead row is never refreshed. A due row that becomes dead before it is served is dropped.
- R4: A granted host write (hostWrite=1) marks its row live. cfgClrValid marks cfgRow dead. If both name the same row in the same cycle, the row ends live.
- R5: With the variable enable high, a row with interval code k (cfgPeriod, 0..3) is refreshed once every 2^k base ticks. Its countdown restarts when the row is refreshed.
- R6: When several rows are due, one is issued per refresh slot, in ascending row index. refRow carries the index in the cycle refCmd is high.
- R7: A refresh holds the array for REF_CYCLES cycles, counting the cycle of refCmd. During that time hostGnt and refCmd stay low.
- R8: In a cycle where the array is free, a host request is granted in that same cycle unless a row is due and the previous grant went to the host. In that case the refresh is issued, so a due row waits behind at most one host access.
- R9: refCount increases by exactly one in the cycle after each refCmd, holds otherwise, and wraps at its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selEn | input | 1 | Skip dead rows |
| varEn | input | 1 | Per-row refresh interval |
| hostReq | input | 1 | Host access request (one cycle when granted) |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostRow | input | ROW_W | Row addressed by the host |
| hostGnt | output | 1 | Host access performed this cycle |
| cfgPerWe | input | 1 | Load cfgPeriod into the interval code of cfgRow |
| cfgClrValid | input | 1 | Mark cfgRow dead |
| cfgRow | input | ROW_W | Row addressed by configuration |
| cfgPeriod | input | PER_W | Interval code k, interval 2^k base ticks |
| refCmd | output | 1 | Refresh issued this cycle |
| refRow | output | ROW_W | Row being refreshed |
| refCount | output | COUNT_W | Total refreshes issued, wrapping |

## Verification
Two functions can meet in the same cycle. A refresh that falls due while the host holds its request continuously competes with that request. A host write and a configuration clear can also target the same row at once. The first is provoked by holding a read request open across whole tick windows. The bench then judges every cycle's grant and refresh against its model, checks that the R7 hold window is never broken, and checks that each row still gets its full share of refreshes. The second is provoked by driving the write and the clear together in a quiet cycle. It is judged through the refreshes that row receives afterwards in selective mode.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // strobes from the control unit to the row datapath
  typedef struct packed {
    logic tick;       // base tick epoch
    logic issueRef;   // refresh of the picked row starts now
    logic hostWrGnt;  // host write granted this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
#(
  parameter int TICK_CYCLES = 256,
  parameter int REF_CYCLES  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReq,
  input  logic        hostWrite,
  input  logic        anyDue,
  output logic        hostGnt,
  output ctrlStrobe_t strobe
);

  localparam int TICK_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int BUSY_W = $clog2(REF_CYCLES + 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_CYCLES - 1);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(REF_CYCLES - 1);

  logic [TICK_W-1:0] tickCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic              lastHost;
  logic              arrayFree;
  logic              issueRef;

  // arbitration: a due row goes ahead of the host after one host access
  always_comb begin
    arrayFree = (busyCnt == '0);
    issueRef  = arrayFree && anyDue && (lastHost || !hostReq);
    hostGnt   = hostReq && arrayFree && !issueRef;
    strobe.tick      = (tickCnt == TICK_LAST);
    strobe.issueRef  = issueRef;
    strobe.hostWrGnt = hostGnt && hostWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt  <= '0;
      busyCnt  <= '0;
      lastHost <= 1'b0;
    end else begin
      tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + 1'b1;
      if (issueRef) begin
        busyCnt  <= BUSY_LOAD;
        lastHost <= 1'b0;
      end else begin
        if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
        if (hostGnt) lastHost <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rfsh_rows.sv
module rfsh_rows
  import rfsh_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int PER_W   = 2,
  parameter int COUNT_W = 16,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic               selEn,
  input  logic               varEn,
  input  logic [ROW_W-1:0]   hostRow,
  input  logic               cfgPerWe,
  input  logic               cfgClrValid,
  input  logic [ROW_W-1:0]   cfgRow,
  input  logic [PER_W-1:0]   cfgPeriod,
  output logic               anyDue,
  output logic [ROW_W-1:0]   pickRow,
  output logic [ROWS-1:0]    validVec,
  output logic [COUNT_W-1:0] refCount
);

  // countdown wide enough for the longest interval minus one
  localparam int RCNT_W = (1 << PER_W) - 1;

  logic [ROWS-1:0] dueVec;
  logic [ROWS-1:0] eligVec;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic              validQ;
    logic              dueQ;
    logic [PER_W-1:0]  perQ;
    logic [RCNT_W-1:0] cntQ;
    logic [RCNT_W-1:0] reloadVal;
    logic              isPicked;
    logic              isDead;

    always_comb begin
      reloadVal = varEn ? RCNT_W'((32'd1 << perQ) - 32'd1) : '0;
      isPicked  = strobe.issueRef && (pickRow == ROW_W'(r));
      isDead    = selEn && !validQ;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ <= 1'b0;
        dueQ   <= 1'b0;
        perQ   <= '0;
        cntQ   <= '0;
      end else begin
        if (cfgClrValid && cfgRow == ROW_W'(r)) validQ <= 1'b0;
        if (strobe.hostWrGnt && hostRow == ROW_W'(r)) validQ <= 1'b1;
        if (cfgPerWe && cfgRow == ROW_W'(r)) perQ <= cfgPeriod;

        if (isPicked) begin
          dueQ <= 1'b0;
          cntQ <= reloadVal;
        end else if (dueQ && isDead) begin
          dueQ <= 1'b0;
          cntQ <= reloadVal;
        end else if (strobe.tick && !dueQ) begin
          if (cntQ == '0) begin
            if (isDead) cntQ <= reloadVal;
            else        dueQ <= 1'b1;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
      end
    end

    assign validVec[r] = validQ;
    assign dueVec[r]   = dueQ;
  end

  // lowest due row wins
  always_comb begin
    eligVec = dueVec & (validVec | {ROWS{~selEn}});
    anyDue  = |eligVec;
    pickRow = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (eligVec[i]) pickRow = ROW_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) refCount <= '0;
    else if (strobe.issueRef) refCount <= refCount + 1'b1;
  end

endmodule

// File: rtl/rfsh_scheduler.sv
module rfsh_scheduler
  import rfsh_pkg::*;
#(
  parameter int ROWS        = 16,
  parameter int PER_W       = 2,
  parameter int TICK_CYCLES = 256,
  parameter int REF_CYCLES  = 4,
  parameter int COUNT_W     = 16,
  localparam int ROW_W      = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               selEn,
  input  logic               varEn,
  input  logic               hostReq,
  input  logic               hostWrite,
  input  logic [ROW_W-1:0]   hostRow,
  output logic               hostGnt,
  input  logic               cfgPerWe,
  input  logic               cfgClrValid,
  input  logic [ROW_W-1:0]   cfgRow,
  input  logic [PER_W-1:0]   cfgPeriod,
  output logic               refCmd,
  output logic [ROW_W-1:0]   refRow,
  output logic [COUNT_W-1:0] refCount
);

  ctrlStrobe_t     strobe;
  logic            anyDue;
  logic [ROWS-1:0] validVec;

  rfsh_ctrl #(
    .TICK_CYCLES(TICK_CYCLES),
    .REF_CYCLES (REF_CYCLES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .anyDue   (anyDue),
    .hostGnt  (hostGnt),
    .strobe   (strobe)
  );

  rfsh_rows #(
    .ROWS   (ROWS),
    .PER_W  (PER_W),
    .COUNT_W(COUNT_W)
  ) i_rows (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .selEn      (selEn),
    .varEn      (varEn),
    .hostRow    (hostRow),
    .cfgPerWe   (cfgPerWe),
    .cfgClrValid(cfgClrValid),
    .cfgRow     (cfgRow),
    .cfgPeriod  (cfgPeriod),
    .anyDue     (anyDue),
    .pickRow    (refRow),
    .validVec   (validVec),
    .refCount   (refCount)
  );

  assign refCmd = strobe.issueRef;

endmodule

// File: rtl/rfsh_checker.sv
module rfsh_checker #(
  parameter int ROWS    = 16,
  parameter int COUNT_W = 16,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input logic               clk,
  input logic               rstN,
  input logic               selEn,
  input logic               hostGnt,
  input logic               hostWrite,
  input logic [ROW_W-1:0]   hostRow,
  input logic               refCmd,
  input logic [ROW_W-1:0]   refRow,
  input logic [COUNT_W-1:0] refCount,
  input logic               anyDue,
  input logic [ROWS-1:0]    validVec
);

  assert_ref_holds_array_R7: assert property (@(posedge clk) disable iff (!rstN)
    refCmd |=> (!hostGnt && !refCmd));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    refCmd |=> (refCount == $past(refCount) + 1'b1));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !refCmd |=> $stable(refCount));

  assert_due_after_host_R8: assert property (@(posedge clk) disable iff (!rstN)
    hostGnt |=> (!anyDue || refCmd));

  assert_write_marks_live_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostGnt && hostWrite) |=> validVec[$past(hostRow)]);

  assert_dead_row_skipped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (refCmd && selEn) |-> validVec[refRow]);

endmodule

bind rfsh_scheduler rfsh_checker #(
  .ROWS   (ROWS),
  .COUNT_W(COUNT_W)
) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .selEn    (selEn),
  .hostGnt  (hostGnt),
  .hostWrite(hostWrite),
  .hostRow  (hostRow),
  .refCmd   (refCmd),
  .refRow   (refRow),
  .refCount (refCount),
  .anyDue   (anyDue),
  .validVec (validVec)
);

// File: tb/test_rfsh_scheduler.sv
module test_rfsh_scheduler;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 8;
  localparam int ROW_W = 3;
  localparam int PER_W = 2;
  localparam int T     = 32;
  localparam int REFC  = 3;
  localparam int CW    = 16;

  logic clk = 0;
  logic rstN = 0;
  logic selEn = 0, varEn = 0;
  logic hostReq = 0, hostWrite = 0;
  logic [ROW_W-1:0] hostRow = '0;
  logic hostGnt;
  logic cfgPerWe = 0, cfgClrValid = 0;
  logic [ROW_W-1:0] cfgRow = '0;
  logic [PER_W-1:0] cfgPeriod = '0;
  logic refCmd;
  logic [ROW_W-1:0] refRow;
  logic [CW-1:0] refCount;

  rfsh_scheduler #(
    .ROWS(ROWS), .PER_W(PER_W), .TICK_CYCLES(T), .REF_CYCLES(REFC), .COUNT_W(CW)
  ) i_rfsh_scheduler (
    .clk(clk), .rstN(rstN), .selEn(selEn), .varEn(varEn),
    .hostReq(hostReq), .hostWrite(hostWrite), .hostRow(hostRow), .hostGnt(hostGnt),
    .cfgPerWe(cfgPerWe), .cfgClrValid(cfgClrValid), .cfgRow(cfgRow), .cfgPeriod(cfgPeriod),
    .refCmd(refCmd), .refRow(refRow), .refCount(refCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // behavioural reference state
  int mValid[ROWS], mPer[ROWS], mCnt[ROWS], mDue[ROWS];
  int mTick, mBusy, mLast, mRefCount;
  int rowRefs[ROWS];
  int totalRefs = 0;
  int sinceRef = 1000;

  function automatic int reloadOf(int r);
    return varEn ? ((1 << mPer[r]) - 1) : 0;
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) begin
        mValid[r] = 0; mPer[r] = 0; mCnt[r] = 0; mDue[r] = 0;
      end
      mTick = 0; mBusy = 0; mLast = 0; mRefCount = 0;
    end else if (!done) begin
      int pick, any, issue, gnt, tick;
      pick = 0; any = 0;
      for (int r = ROWS - 1; r >= 0; r--)
        if (mDue[r] != 0 && (mValid[r] != 0 || !selEn)) begin pick = r; any = 1; end
      tick  = (mTick == T - 1);
      issue = (mBusy == 0) && any && (mLast != 0 || !hostReq);
      gnt   = hostReq && (mBusy == 0) && !issue;

      chk(refCmd === 1'(issue), "R2", "refCmd", int'(refCmd), issue);
      if (issue) chk(refRow == ROW_W'(pick), "R6", "refRow", int'(refRow), pick);
      chk(hostGnt === 1'(gnt), "R8", "hostGnt", int'(hostGnt), gnt);
      chk(refCount == CW'(mRefCount), "R9", "refCount", int'(refCount), mRefCount);

      // hold window, judged from the outputs alone
      if (refCmd || hostGnt) begin
        chk(sinceRef >= REFC, "R7", "grant inside refresh hold", sinceRef, REFC);
      end
      if (refCmd) begin
        sinceRef = 1;
        rowRefs[refRow]++;
        totalRefs++;
      end else if (sinceRef < 1000) sinceRef++;

      // advance the reference
      for (int r = 0; r < ROWS; r++) begin
        int dead;
        dead = selEn && (mValid[r] == 0);
        if (issue && r == pick) begin
          mDue[r] = 0; mCnt[r] = reloadOf(r);
        end else if (mDue[r] != 0 && dead) begin
          mDue[r] = 0; mCnt[r] = reloadOf(r);
        end else if (tick && mDue[r] == 0) begin
          if (mCnt[r] == 0) begin
            if (dead) mCnt[r] = reloadOf(r); else mDue[r] = 1;
          end else mCnt[r]--;
        end
        if (cfgClrValid && cfgRow == ROW_W'(r)) mValid[r] = 0;
        if (gnt && hostWrite && hostRow == ROW_W'(r)) mValid[r] = 1;
        if (cfgPerWe && cfgRow == ROW_W'(r)) mPer[r] = int'(cfgPeriod);
      end
      mTick = tick ? 0 : mTick + 1;
      if (issue) begin mBusy = REFC - 1; mLast = 0; end
      else begin
        if (mBusy > 0) mBusy--;
        if (gnt) mLast = 1;
      end
      if (issue) mRefCount = (mRefCount + 1) % (1 << CW);
    end
  end

  task automatic align();
    do begin @(posedge clk); #1; end while (mTick != 0);
  endtask

  task automatic runWindows(input int n);
    repeat (n * T) @(posedge clk);
    #1;
  endtask

  task automatic clearRefs();
    for (int r = 0; r < ROWS; r++) rowRefs[r] = 0;
  endtask

  // drives in a cycle where no refresh can be pending
  task automatic quietOp(input bit doWrite, input int wRow,
                         input bit doClr, input bit doPer, input int cRow, input int per);
    align();
    repeat (28) @(posedge clk);
    #1;
    hostReq = doWrite; hostWrite = doWrite; hostRow = ROW_W'(wRow);
    cfgClrValid = doClr; cfgPerWe = doPer; cfgRow = ROW_W'(cRow); cfgPeriod = PER_W'(per);
    @(posedge clk); #1;
    hostReq = 0; hostWrite = 0; cfgClrValid = 0; cfgPerWe = 0;
  endtask

  task automatic expectRefs(input string req, input int e0, input int e1, input int e2,
                            input int e3, input int e4, input int e5, input int e6, input int e7);
    int e[ROWS];
    e = '{e0, e1, e2, e3, e4, e5, e6, e7};
    for (int r = 0; r < ROWS; r++)
      chk(rowRefs[r] == e[r], req, $sformatf("refreshes of row %0d", r), rowRefs[r], e[r]);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk(refCmd == 0, "R1", "refCmd after reset", int'(refCmd), 0);
    chk(refCount == 0, "R1", "refCount after reset", int'(refCount), 0);
    chk(hostGnt == 0, "R1", "hostGnt idle", int'(hostGnt), 0);
    repeat (T - 3) @(negedge clk);
    chk(totalRefs == 0, "R1", "refreshes before first tick", totalRefs, 0);

    // R2: fixed interval, every row every tick
    align(); runWindows(1); clearRefs(); runWindows(4);
    expectRefs("R2", 4, 4, 4, 4, 4, 4, 4, 4);

    // R3: selective, only rows 1, 4, 6 live
    selEn = 1;
    quietOp(1, 1, 0, 0, 0, 0);
    quietOp(1, 4, 0, 0, 0, 0);
    quietOp(1, 6, 0, 0, 0, 0);
    align(); runWindows(1); clearRefs(); runWindows(4);
    expectRefs("R3", 0, 4, 0, 0, 4, 0, 4, 0);

    // R4: clear row 4; write and clear row 6 together (write wins)
    quietOp(0, 0, 1, 0, 4, 0);
    quietOp(1, 6, 1, 0, 6, 0);
    align(); runWindows(1); clearRefs(); runWindows(4);
    expectRefs("R4", 0, 4, 0, 0, 0, 0, 4, 0);

    // R5: variable intervals: row1 k=3, row2 k=2, row6 k=1
    quietOp(0, 0, 0, 1, 1, 3);
    quietOp(0, 0, 0, 1, 6, 1);
    quietOp(1, 2, 0, 1, 2, 2);
    varEn = 1;
    align(); runWindows(8); clearRefs(); runWindows(8);
    expectRefs("R5", 0, 1, 2, 0, 0, 0, 4, 0);

    // R8: host holds a read open, refreshes still get every slot
    selEn = 0; varEn = 0;
    align();
    hostReq = 1; hostWrite = 0; hostRow = 3;
    runWindows(1); clearRefs(); runWindows(4);
    expectRefs("R8", 4, 4, 4, 4, 4, 4, 4, 4);
    hostReq = 0;
    runWindows(1);

    // R9: exported total matches observed commands
    @(negedge clk);
    chk(refCount == CW'(totalRefs), "R9", "refCount total", int'(refCount), totalRefs);
    finish();
  end

endmodule